// File: doc/BRIEF.md
# Eight-bit ALU with side accumulator

This block is the arithmetic and logic unit of a small 8-bit RISC core. Every operation writes an 8-bit side accumulator, and for ordinary operations that value is the same as the result. Some operations also update carry (C), overflow (V) and zero (Z). The unit takes two operands, a 3-bit shift or bit index and an operation code. It returns the result, a result write enable, the new accumulator value, and the next value and write enable of each flag. Decode and the register file sit outside. The block holds the three flags itself, so the carry-in forms and the flag-export operation read the stored flags.

Subtraction uses carry as an active-low borrow. C is 1 when no borrow occurred. A multiply splits its 16-bit product: the upper byte goes to the result and the lower byte to the accumulator. A multi-bit shift places the bits it moves out of the byte into the accumulator. Compares and bit tests update flags and the accumulator but do not write a result. The operation code is the `alu_op_e` enumeration in `alu8_pkg`, numbered 0 to 21 in this order: AND, OR, XOR, ADD, ADDC, SUBD, SUBDC, SUBS, SUBSC, MUL, MULA, MSHL, MSHR, MSHRA, CMP, CMPA, TSTB, SETB, CLRB, INVB, SFLAG, PASS. Codes 22 to 31 produce zero outputs and assert no write enables.

Top module: `alu8_acc`

## Requirements
- R1: AND, OR and XOR return the bitwise function of opa and opb. They assert res_we and z_we only, and Z is 1 when the result is zero.
- R2: ADD returns opa+opb modulo 256 and ADDC also adds the stored C. C is the carry out, V is signed two's-complement overflow, Z marks a zero result, and all three write enables are set.
- R3: SUBD returns opa-opb and SUBS returns opb-opa. SUBDC and SUBSC also subtract (1-C). C is 0 when a borrow occurs and 1 otherwise, V is signed overflow, Z marks a zero result, and all three write enables are set.
- R4: MUL (unsigned) and MULA (two's complement) put bits 15:8 of the product on res and bits 7:0 on acc, with res_we set and no flag write enable.
- R5: With s = amt, MSHL gives acc = opa<<s and res = opa>>(8-s). MSHR gives res = opa>>s and acc = opa<<(8-s). MSHRA gives res = the arithmetic right shift of opa by s and acc = opa<<(8-s). All three set res_we and write no flag.
- R6: CMP (unsigned) and CMPA (signed) set C to 0 when opb is greater than opa and to 1 otherwise, Z = (opa==opb) and V = C AND NOT Z. They write all three flags, leave res_we at 0, and set acc = opa-opb modulo 256.
- R7: TSTB sets Z to the inverse of opa bit amt, writes only Z and acc = opa, and leaves res_we at 0. SETB, CLRB and INVB set, clear or invert opa bit amt. They assert res_we and z_we, and Z marks a zero result.
- R8: SFLAG sets acc bit 7 to the stored C, bit 6 to C XOR V and the other bits to 0. It asserts no result or flag write enable.
- R9: Apart from the multiplies, the multi-bit shifts and SFLAG, acc equals the computed result value.
- R10: Reset clears flag_c, flag_v and flag_z. On a rising clock edge with exec_en high, each flag whose write enable is set loads its next value. All other flags hold.
- R11: PASS returns opb, with res_we and z_we set and Z marking a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| exec_en | input | 1 | Commit the flag updates of this operation |
| op | input | 5 | Operation code (alu_op_e) |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| amt | input | 3 | Shift amount or bit index |
| res | output | 8 | Result value |
| res_we | output | 1 | Result is to be written back |
| acc | output | 8 | New accumulator value |
| c_nxt | output | 1 | Next carry |
| v_nxt | output | 1 | Next overflow |
| z_nxt | output | 1 | Next zero |
| c_we | output | 1 | Carry write enable |
| v_we | output | 1 | Overflow write enable |
| z_we | output | 1 | Zero write enable |
| flag_c | output | 1 | Stored carry |
| flag_v | output | 1 | Stored overflow |
| flag_z | output | 1 | Stored zero |

## Verification
Some properties are checked on every cycle. Multiplies never raise a flag enable. Logic operations enable only Z. A compare's V always equals C AND NOT Z. A logical multi-bit shift keeps the total count of set bits across result and accumulator equal to that of the operand. Ordinary operations keep acc equal to res, and a carry with no enable holds across an execute. The numerical results need the bench's reference model across random and directed patterns. These include the carry and borrow paths that depend on the stored C, signed overflow at 0x7F and 0x80, products of 0x80, shifts by 0 and 7, and SFLAG after known flag states.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [4:0] {
      OP_AND, OP_OR, OP_XOR,
      OP_ADD, OP_ADDC,
      OP_SUBD, OP_SUBDC, OP_SUBS, OP_SUBSC,
      OP_MUL, OP_MULA,
      OP_MSHL, OP_MSHR, OP_MSHRA,
      OP_CMP, OP_CMPA,
      OP_TSTB, OP_SETB, OP_CLRB, OP_INVB,
      OP_SFLAG, OP_PASS
   } alu_op_e;

   localparam int NUM_OPS = 22;

   typedef enum logic [1:0] {
      SH_LEFT, SH_RIGHT, SH_RIGHT_ARITH
   } shift_kind_e;

   typedef enum logic [1:0] {
      BIT_SET, BIT_CLR, BIT_INV, BIT_TEST
   } bit_kind_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         inv_y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   logic [W-1:0] y_eff;
   logic [W:0]   total;

   initial begin
      assert (W >= 2) else $error("alu8_addsub: W must be at least 2");
   end

   // subtraction is x + ~y + cin; cin=1 is a plain subtract
   assign y_eff = inv_y ? ~y : y;
   assign total = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
   assign sum   = total[W-1:0];
   assign cout  = total[W];
   assign ovf   = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
   parameter int W           = 8,
   parameter bit SIGNED_MODE = 1'b0
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] hi,
   output logic [W-1:0] lo
);
   logic [2*W-1:0] x_ext;
   logic [2*W-1:0] y_ext;
   logic [2*W-1:0] prod;

   initial begin
      assert (W >= 2) else $error("alu8_mul: W must be at least 2");
   end

   generate
      if (SIGNED_MODE) begin : g_signed
         assign x_ext = {{W{x[W-1]}}, x};
         assign y_ext = {{W{y[W-1]}}, y};
      end else begin : g_unsigned
         assign x_ext = {{W{1'b0}}, x};
         assign y_ext = {{W{1'b0}}, y};
      end
   endgenerate

   // low 2W bits of the extended product are exact in both modes
   assign prod = x_ext * y_ext;
   assign hi   = prod[2*W-1:W];
   assign lo   = prod[W-1:0];
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
   import alu8_pkg::*;
#(
   parameter int W  = 8,
   parameter int SW = $clog2(W)
) (
   input  logic [W-1:0]  x,
   input  logic [SW-1:0] amt,
   input  shift_kind_e   kind,
   output logic [W-1:0]  r,
   output logic [W-1:0]  a
);
   logic [SW:0]         comp;
   logic signed [W-1:0] xs;
   logic signed [W-1:0] sra;

   initial begin
      assert ((1 << SW) == W) else $error("alu8_shift: W must be a power of two");
   end

   assign comp = (SW + 1)'(W) - {1'b0, amt};
   assign xs   = $signed(x);
   assign sra  = xs >>> amt;

   always_comb begin
      unique case (kind)
         SH_LEFT: begin
            a = x << amt;
            r = x >> comp;
         end
         SH_RIGHT: begin
            r = x >> amt;
            a = x << comp;
         end
         default: begin
            r = sra;
            a = x << comp;
         end
      endcase
   end
endmodule

// File: rtl/alu8_bitop.sv
module alu8_bitop
   import alu8_pkg::*;
#(
   parameter int W  = 8,
   parameter int SW = $clog2(W)
) (
   input  logic [W-1:0]  x,
   input  logic [SW-1:0] amt,
   input  bit_kind_e     kind,
   output logic [W-1:0]  r,
   output logic          bit_val
);
   logic [W-1:0] mask;

   assign mask    = {{(W-1){1'b0}}, 1'b1} << amt;
   assign bit_val = |(x & mask);

   always_comb begin
      unique case (kind)
         BIT_SET: r = x | mask;
         BIT_CLR: r = x & ~mask;
         BIT_INV: r = x ^ mask;
         default: r = x;
      endcase
   end
endmodule

// File: rtl/alu8_acc.sv
module alu8_acc
   import alu8_pkg::*;
#(
   parameter  int W  = 8,
   localparam int SW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          exec_en,
   input  logic [4:0]    op,
   input  logic [W-1:0]  opa,
   input  logic [W-1:0]  opb,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  res,
   output logic          res_we,
   output logic [W-1:0]  acc,
   output logic          c_nxt,
   output logic          v_nxt,
   output logic          z_nxt,
   output logic          c_we,
   output logic          v_we,
   output logic          z_we,
   output logic          flag_c,
   output logic          flag_v,
   output logic          flag_z
);
   localparam int NMUL = 2;

   initial begin
      assert (W >= 4) else $error("alu8_acc: W must be at least 4");
      assert ((1 << SW) == W) else $error("alu8_acc: W must be a power of two");
   end

   alu_op_e op_e;
   assign op_e = alu_op_e'(op);

   // ---------------- adder operand selection ----------------
   logic [W-1:0] add_x, add_y, add_sum;
   logic         add_inv, add_cin, add_cout, add_ovf;

   always_comb begin
      add_x   = opa;
      add_y   = opb;
      add_inv = 1'b0;
      add_cin = 1'b0;
      unique case (op_e)
         OP_ADDC:                  add_cin = flag_c;
         OP_SUBD, OP_CMP, OP_CMPA: begin add_inv = 1'b1; add_cin = 1'b1;   end
         OP_SUBDC:                 begin add_inv = 1'b1; add_cin = flag_c; end
         OP_SUBS, OP_SUBSC: begin
            add_x   = opb;
            add_y   = opa;
            add_inv = 1'b1;
            add_cin = (op_e == OP_SUBS) ? 1'b1 : flag_c;
         end
         default: ;
      endcase
   end

   alu8_addsub #(.W(W)) u_addsub (
      .x(add_x), .y(add_y), .inv_y(add_inv), .cin(add_cin),
      .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
   );

   // ---------------- multipliers: [0] unsigned, [1] signed ----------------
   logic [W-1:0] mul_hi [NMUL];
   logic [W-1:0] mul_lo [NMUL];

   generate
      for (genvar g = 0; g < NMUL; g++) begin : g_mul
         alu8_mul #(.W(W), .SIGNED_MODE(g == 1)) u_mul (
            .x(opa), .y(opb), .hi(mul_hi[g]), .lo(mul_lo[g])
         );
      end
   endgenerate

   // ---------------- multi-bit shifter ----------------
   shift_kind_e  sh_kind;
   logic [W-1:0] sh_r, sh_a;

   always_comb begin
      unique case (op_e)
         OP_MSHL: sh_kind = SH_LEFT;
         OP_MSHR: sh_kind = SH_RIGHT;
         default: sh_kind = SH_RIGHT_ARITH;
      endcase
   end

   alu8_shift #(.W(W), .SW(SW)) u_shift (
      .x(opa), .amt(amt), .kind(sh_kind), .r(sh_r), .a(sh_a)
   );

   // ---------------- single-bit unit ----------------
   bit_kind_e    bk_kind;
   logic [W-1:0] bk_r;
   logic         bk_bit;

   always_comb begin
      unique case (op_e)
         OP_SETB: bk_kind = BIT_SET;
         OP_CLRB: bk_kind = BIT_CLR;
         OP_INVB: bk_kind = BIT_INV;
         default: bk_kind = BIT_TEST;
      endcase
   end

   alu8_bitop #(.W(W), .SW(SW)) u_bitop (
      .x(opa), .amt(amt), .kind(bk_kind), .r(bk_r), .bit_val(bk_bit)
   );

   // ---------------- result / flag selection ----------------
   logic [W-1:0] val;

   always_comb begin
      val    = '0;
      acc    = '0;
      res_we = 1'b0;
      c_we   = 1'b0;
      v_we   = 1'b0;
      z_we   = 1'b0;
      c_nxt  = 1'b0;
      v_nxt  = 1'b0;
      z_nxt  = 1'b0;
      unique case (op_e)
         OP_AND, OP_OR, OP_XOR, OP_PASS: begin
            unique case (op_e)
               OP_AND:  val = opa & opb;
               OP_OR:   val = opa | opb;
               OP_XOR:  val = opa ^ opb;
               default: val = opb;
            endcase
            acc    = val;
            res_we = 1'b1;
            z_we   = 1'b1;
            z_nxt  = (val == '0);
         end
         OP_ADD, OP_ADDC, OP_SUBD, OP_SUBDC, OP_SUBS, OP_SUBSC: begin
            val    = add_sum;
            acc    = val;
            res_we = 1'b1;
            {c_we, v_we, z_we} = 3'b111;
            c_nxt  = add_cout;
            v_nxt  = add_ovf;
            z_nxt  = (add_sum == '0);
         end
         OP_MUL, OP_MULA: begin
            val    = mul_hi[(op_e == OP_MULA) ? 1 : 0];
            acc    = mul_lo[(op_e == OP_MULA) ? 1 : 0];
            res_we = 1'b1;
         end
         OP_MSHL, OP_MSHR, OP_MSHRA: begin
            val    = sh_r;
            acc    = sh_a;
            res_we = 1'b1;
         end
         OP_CMP, OP_CMPA: begin
            val   = add_sum;
            acc   = val;
            {c_we, v_we, z_we} = 3'b111;
            z_nxt = (opa == opb);
            c_nxt = (op_e == OP_CMP) ? add_cout
                                     : !($signed(opb) > $signed(opa));
            v_nxt = c_nxt & ~z_nxt;
         end
         OP_TSTB: begin
            val   = opa;
            acc   = val;
            z_we  = 1'b1;
            z_nxt = ~bk_bit;
         end
         OP_SETB, OP_CLRB, OP_INVB: begin
            val    = bk_r;
            acc    = val;
            res_we = 1'b1;
            z_we   = 1'b1;
            z_nxt  = (bk_r == '0);
         end
         OP_SFLAG: begin
            acc = {flag_c, flag_c ^ flag_v, {(W-2){1'b0}}};
            val = acc;
         end
         default: ;
      endcase
   end

   assign res = val;

   // ---------------- flag register ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_c <= 1'b0;
         flag_v <= 1'b0;
         flag_z <= 1'b0;
      end else if (exec_en) begin
         if (c_we) flag_c <= c_nxt;
         if (v_we) flag_v <= v_nxt;
         if (z_we) flag_z <= z_nxt;
      end
   end

   // ---------------- assertions ----------------
   AST_LOGIC_ONLY_Z: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e inside {OP_AND, OP_OR, OP_XOR}) |-> (z_we && !c_we && !v_we)); // R1
   AST_MUL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e inside {OP_MUL, OP_MULA}) |-> (!c_we && !v_we && !z_we && res_we)); // R4
   AST_SHIFT_CONSERVES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e inside {OP_MSHL, OP_MSHR}) |-> ($countones(res) + $countones(acc) == $countones(opa))); // R5
   AST_CMP_V_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e inside {OP_CMP, OP_CMPA}) |-> (v_nxt == (c_nxt && !z_nxt) && !res_we)); // R6
   AST_SFLAG_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_SFLAG) |-> (!c_we && !v_we && !z_we && acc[W-1] == flag_c)); // R8
   AST_ACC_TRACKS_RES: assert property (@(posedge clk) disable iff (!rst_n)
      (res_we && !(op_e inside {OP_MUL, OP_MULA, OP_MSHL, OP_MSHR, OP_MSHRA})) |-> (acc == res)); // R9
   AST_CARRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_en || !c_we) |=> $stable(flag_c)); // R10
endmodule

// File: tb/sim_alu8_acc.sv
`timescale 1ns/1ps
module sim_alu8_acc;
   import alu8_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       exec_en = 1'b0;
   logic [4:0] op = 5'd0;
   logic [7:0] opa = 8'h00, opb = 8'h00;
   logic [2:0] amt = 3'd0;
   logic [7:0] res, acc;
   logic       res_we, c_nxt, v_nxt, z_nxt, c_we, v_we, z_we;
   logic       flag_c, flag_v, flag_z;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // model flags
   logic mc = 1'b0, mv = 1'b0, mz = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   alu8_acc u0 (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op), .opa(opa), .opb(opb),
      .amt(amt), .res(res), .res_we(res_we), .acc(acc), .c_nxt(c_nxt), .v_nxt(v_nxt),
      .z_nxt(z_nxt), .c_we(c_we), .v_we(v_we), .z_we(z_we),
      .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z)
   );

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   function automatic int sval(input logic [7:0] x);
      return (x > 8'd127) ? int'(x) - 256 : int'(x);
   endfunction

   function automatic string req_of(input alu_op_e o);
      case (o)
         OP_AND, OP_OR, OP_XOR:                               return "R1";
         OP_ADD, OP_ADDC:                                     return "R2";
         OP_SUBD, OP_SUBDC, OP_SUBS, OP_SUBSC:                return "R3";
         OP_MUL, OP_MULA:                                     return "R4";
         OP_MSHL, OP_MSHR, OP_MSHRA:                          return "R5";
         OP_CMP, OP_CMPA:                                     return "R6";
         OP_TSTB, OP_SETB, OP_CLRB, OP_INVB:                  return "R7";
         OP_SFLAG:                                            return "R8";
         default:                                             return "R11";
      endcase
   endfunction

   // reference model written from the requirements
   task automatic model(input alu_op_e o, input logic [7:0] a, input logic [7:0] b,
                        input int s, input logic c, input logic v,
                        output logic [7:0] er, output logic [7:0] ea, output logic erw,
                        output logic [2:0] ewe, output logic [2:0] ef);
      int t, st, x, y, bw;
      er = 8'h00; ea = 8'h00; erw = 1'b0; ewe = 3'b000; ef = 3'b000;
      case (o)
         OP_AND, OP_OR, OP_XOR, OP_PASS: begin              // R1 R11 R9
            er  = (o == OP_AND) ? (a & b) : (o == OP_OR) ? (a | b) :
                  (o == OP_XOR) ? (a ^ b) : b;
            ea  = er; erw = 1'b1; ewe = 3'b001; ef[0] = (er == 0);
         end
         OP_ADD, OP_ADDC: begin                             // R2
            t  = int'(a) + int'(b) + ((o == OP_ADDC) ? int'(c) : 0);
            st = sval(a) + sval(b) + ((o == OP_ADDC) ? int'(c) : 0);
            er = t[7:0]; ea = er; erw = 1'b1; ewe = 3'b111;
            ef = {t > 255, (st > 127 || st < -128), er == 0};
         end
         OP_SUBD, OP_SUBDC, OP_SUBS, OP_SUBSC: begin        // R3
            bw = (o == OP_SUBDC || o == OP_SUBSC) ? 1 - int'(c) : 0;
            x  = (o == OP_SUBS || o == OP_SUBSC) ? int'(b) : int'(a);
            y  = (o == OP_SUBS || o == OP_SUBSC) ? int'(a) : int'(b);
            t  = x - y - bw;
            st = sval(x[7:0]) - sval(y[7:0]) - bw;
            er = t[7:0]; ea = er; erw = 1'b1; ewe = 3'b111;
            ef = {t >= 0, (st > 127 || st < -128), er == 0};
         end
         OP_MUL: begin                                       // R4
            t = int'(a) * int'(b);
            er = t[15:8]; ea = t[7:0]; erw = 1'b1;
         end
         OP_MULA: begin
            t = sval(a) * sval(b);
            er = t[15:8]; ea = t[7:0]; erw = 1'b1;
         end
         OP_MSHL, OP_MSHR, OP_MSHRA: begin                   // R5
            erw = 1'b1;
            for (int n = 0; n < 8; n++) begin
               if (o == OP_MSHL) begin
                  if (n >= s) ea[n] = a[n-s];
                  else        er[n] = a[n+8-s];
               end else begin
                  if (n + s < 8) er[n] = a[n+s];
                  else begin
                     ea[n] = a[n-8+s];
                     er[n] = (o == OP_MSHRA) ? a[7] : 1'b0;
                  end
               end
            end
         end
         OP_CMP, OP_CMPA: begin                              // R6
            t  = int'(a) - int'(b);
            ea = t[7:0]; ewe = 3'b111;
            ef[2] = (o == OP_CMP) ? !(b > a) : !(sval(b) > sval(a));
            ef[0] = (a == b);
            ef[1] = ef[2] && !ef[0];
         end
         OP_TSTB: begin                                      // R7
            ea = a; ewe = 3'b001; ef[0] = !a[s];
         end
         OP_SETB, OP_CLRB, OP_INVB: begin
            er = a;
            er[s] = (o == OP_SETB) ? 1'b1 : (o == OP_CLRB) ? 1'b0 : !a[s];
            ea = er; erw = 1'b1; ewe = 3'b001; ef[0] = (er == 0);
         end
         default: begin                                      // R8 SFLAG
            ea = {c, c ^ v, 6'b000000};
         end
      endcase
   endtask

   task automatic run_op(input alu_op_e o, input logic [7:0] a, input logic [7:0] b,
                         input int s, input logic en);
      logic [7:0] er, ea;
      logic       erw;
      logic [2:0] ewe, ef, got_f;
      bit         bad;
      @(negedge clk);
      // R10: stored flags follow the model
      checks++;
      if ({flag_c, flag_v, flag_z} !== {mc, mv, mz}) begin
         errors++;
         $display("FAIL R10 flags: actual %b expected %b", {flag_c, flag_v, flag_z}, {mc, mv, mz});
      end
      op = 5'(o); opa = a; opb = b; amt = 3'(s); exec_en = en;
      model(o, a, b, s, mc, mv, er, ea, erw, ewe, ef);
      #1;
      got_f = {c_nxt, v_nxt, z_nxt};
      bad = (res_we !== erw) || (acc !== ea) || ({c_we, v_we, z_we} !== ewe) ||
            (erw && res !== er) ||
            (ewe[2] && got_f[2] !== ef[2]) || (ewe[1] && got_f[1] !== ef[1]) ||
            (ewe[0] && got_f[0] !== ef[0]);
      checks++;
      if (bad) begin
         errors++;
         $display("FAIL %s (R9 acc) op=%s a=%h b=%h s=%0d: actual res=%h we=%b acc=%h fwe=%b f=%b expected res=%h we=%b acc=%h fwe=%b f=%b",
                  req_of(o), o.name(), a, b, s, res, res_we, acc, {c_we, v_we, z_we}, got_f,
                  er, erw, ea, ewe, ef);
      end
      if (en) begin
         if (ewe[2]) mc = ef[2];
         if (ewe[1]) mv = ef[1];
         if (ewe[0]) mz = ef[0];
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // reset with exec pulses: flags must stay cleared (R10)
      exec_en = 1'b1; op = 5'(OP_CMP); opa = 8'h05; opb = 8'h05;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      exec_en = 1'b0;

      // directed corners
      run_op(OP_ADD,   8'h7F, 8'h01, 0, 1'b1);   // R2 signed overflow
      run_op(OP_ADD,   8'hFF, 8'h01, 0, 1'b1);   // R2 carry and zero
      run_op(OP_ADDC,  8'h10, 8'h20, 0, 1'b1);   // R2 adds stored C=1
      run_op(OP_SUBD,  8'h00, 8'h01, 0, 1'b1);   // R3 borrow clears C
      run_op(OP_SUBDC, 8'h05, 8'h02, 0, 1'b1);   // R3 subtracts 1-C
      run_op(OP_SUBS,  8'h80, 8'h00, 0, 1'b1);   // R3 reverse, overflow
      run_op(OP_SUBSC, 8'h01, 8'h01, 0, 1'b1);   // R3
      run_op(OP_MUL,   8'hFF, 8'hFF, 0, 1'b1);   // R4
      run_op(OP_MULA,  8'h80, 8'h80, 0, 1'b1);   // R4 0x4000
      run_op(OP_MULA,  8'hFF, 8'h02, 0, 1'b1);   // R4 -2
      run_op(OP_MSHL,  8'hA5, 8'h00, 0, 1'b1);   // R5 s=0
      run_op(OP_MSHL,  8'hA5, 8'h00, 7, 1'b1);   // R5 s=7
      run_op(OP_MSHR,  8'hC3, 8'h00, 0, 1'b1);   // R5
      run_op(OP_MSHRA, 8'h90, 8'h00, 3, 1'b1);   // R5 sign fill
      run_op(OP_CMP,   8'h33, 8'h33, 0, 1'b1);   // R6 equal
      run_op(OP_CMP,   8'h01, 8'hFF, 0, 1'b1);   // R6 op2 greater
      run_op(OP_CMPA,  8'h01, 8'hFF, 0, 1'b1);   // R6 signed: -1 < 1
      run_op(OP_TSTB,  8'h08, 8'h00, 3, 1'b1);   // R7
      run_op(OP_CLRB,  8'h01, 8'h00, 0, 1'b1);   // R7 zero result
      run_op(OP_ADD,   8'h7F, 8'h7F, 0, 1'b1);   // sets C=0 V=1
      run_op(OP_SFLAG, 8'h00, 8'h00, 0, 1'b1);   // R8
      run_op(OP_ADD,   8'hFF, 8'h01, 0, 1'b0);   // R10 no execute: flags hold
      run_op(OP_PASS,  8'h12, 8'h00, 0, 1'b1);   // R11
      run_op(OP_SFLAG, 8'h00, 8'h00, 0, 1'b1);   // R8 after Z update only

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         alu_op_e o;
         o = alu_op_e'($urandom % NUM_OPS);
         run_op(o, 8'($urandom), 8'($urandom), int'($urandom % 8), ($urandom % 4) != 0);
      end

      @(negedge clk);
      checks++;
      if ({flag_c, flag_v, flag_z} !== {mc, mv, mz}) begin
         errors++;
         $display("FAIL R10 final flags: actual %b expected %b", {flag_c, flag_v, flag_z}, {mc, mv, mz});
      end
      finish_run();
   end
endmodule